// File: doc/BRIEF.md
# DMA Data Checksum Sniffer

The sniffer sits beside a multi-channel DMA engine and watches the data words that the engine moves. Software picks one channel to observe. Each word that channel transfers is folded into a running 32-bit result. The result can be a CRC-32, a CRC-16-CCITT, a parity bit or a modular sum. This lets software verify a transfer without touching the data a second time.

A small register port reaches two registers: a control word at word offset 0 and the result at word offset 1. Software seeds the result, writes the control word, lets the DMA run, and then reads the result. Two options on the input side can change each word before it is folded in: a byte swap and a full bit reversal. Two options on the read side affect only the returned value: a bit reversal and a complement.

Top module: `dma_cksum_sniffer`

## Requirements
- R1: After reset, the control word and the result both read as zero.
- R2: Offset 0 reads back the control word in bits 11:0, with bits 31:12 zero. Offsets 2 and 3 read as zero. The control layout is: enable at bit 0, channel select at bits 4:1, mode at bits 8:5, input byte swap at bit 9, read bit-reverse at bit 10, read complement at bit 11.
- R3: In mode 0, each accepted word updates the result as a CRC-32 with polynomial 0x04C11DB7. All 32 data bits are processed MSB first within one clock.
- R4: In mode 2, each accepted word updates bits 15:0 as a CRC-16 with polynomial 0x1021, processed MSB first over all 32 bits. Bits 31:16 become zero.
- R5: Modes 1 and 3 work as modes 0 and 2, except that the full 32-bit word is bit-reversed first. This reversal is applied after any byte swap.
- R6: In mode 14, each accepted word clears bits 31:1 of the result. Bit 0 is inverted when the word holds an odd number of one bits.
- R7: In mode 15, each accepted word is added to the result modulo 2^32.
- R8: When bit 9 is set, the four bytes of each word are put in reverse order before any other processing.
- R9: A transfer changes the result only when the enable bit is set and the transfer's channel equals the channel select field.
- R10: Bit 10 reverses and bit 11 complements the value read at offset 1. The stored result and the later updates are not changed by either bit.
- R11: A write to offset 1 loads the result. If an accepted transfer arrives in the same cycle, the write wins.
- R12: Any mode code other than 0, 1, 2, 3, 14 and 15 leaves the result unchanged.
- R13: A control write takes effect from the next cycle. A transfer in the same cycle as the write is processed with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| obs_valid | input | 1 | A DMA word transfer is present this cycle |
| obs_chan | input | 4 | Channel number of the transfer |
| obs_data | input | 32 | Transferred data word |

## Verification
The properties assume that reg_addr, reg_wr, obs_valid and obs_chan are known whenever reset is released. They also assume that the write strobe lasts exactly one cycle per access. The bench drives every input on the falling edge and never leaves an input undefined. Each register write is held for a single cycle, and observation traffic is interleaved freely with writes, including writes that land in the same cycle as a transfer.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

   localparam int CTRL_W = 12;
   localparam int SEL_W  = 4;
   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      M_CRC32    = 4'd0,
      M_CRC32_BR = 4'd1,
      M_CRC16    = 4'd2,
      M_CRC16_BR = 4'd3,
      M_PARITY   = 4'd14,
      M_SUM      = 4'd15
   } sniff_mode_e;

   typedef struct packed {
      logic              rd_inv;
      logic              rd_rev;
      logic              in_swap;
      logic [MODE_W-1:0] mode;
      logic [SEL_W-1:0]  chan;
      logic              en;
   } sniff_ctrl_t;

   // One CRC step over a full 32-bit word, MSB first. 'wide' selects
   // the 32-bit register width; otherwise only bits 15:0 are live.
   function automatic logic [31:0] crc_fold(input logic [31:0] acc,
                                            input logic [31:0] din,
                                            input logic [31:0] poly,
                                            input logic        wide);
      logic [31:0] c;
      logic        fb;
      c = acc;
      for (int i = 31; i >= 0; i--) begin
         fb = (wide ? c[31] : c[15]) ^ din[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      if (!wide) c[31:16] = '0;
      return c;
   endfunction

endpackage

// File: rtl/sniff_ctrl_reg.sv
module sniff_ctrl_reg
   import sniff_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   output sniff_ctrl_t       ctrl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= sniff_ctrl_t'(wdata);
   end

endmodule

// File: rtl/sniff_in_xform.sv
module sniff_in_xform #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   input  logic              swap_en,
   input  logic              rev_en,
   output logic [DATA_W-1:0] dout
);

   localparam int NBYTES = DATA_W / 8;

   logic [DATA_W-1:0] swapped;
   logic [DATA_W-1:0] reversed;
   logic [DATA_W-1:0] stage1;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign swapped[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
   end

   assign stage1 = swap_en ? swapped : din;

   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      assign reversed[k] = stage1[DATA_W-1-k];
   end

   assign dout = rev_en ? reversed : stage1;

endmodule

// File: rtl/sniff_accum.sv
module sniff_accum
   import sniff_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter logic [31:0] CRC32_POLY = 32'h04C1_1DB7,
   parameter logic [15:0] CRC16_POLY = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [MODE_W-1:0] mode,
   input  logic [DATA_W-1:0] din,
   input  logic              ld,
   input  logic [DATA_W-1:0] ld_val,
   output logic [DATA_W-1:0] acc_q
);

   localparam logic [31:0] POLY16_EXT = {16'h0000, CRC16_POLY};

   logic [DATA_W-1:0] nxt;

   always_comb begin
      nxt = acc_q;
      case (mode)
         M_CRC32, M_CRC32_BR: nxt = crc_fold(acc_q, din, CRC32_POLY, 1'b1);
         M_CRC16, M_CRC16_BR: nxt = crc_fold(acc_q, din, POLY16_EXT, 1'b0);
         M_PARITY:            nxt = {{(DATA_W-1){1'b0}}, acc_q[0] ^ (^din)};
         M_SUM:               nxt = acc_q + din;
         default:             nxt = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (ld)  acc_q <= ld_val;
      else if (upd) acc_q <= nxt;
   end

endmodule

// File: rtl/sniff_rd_xform.sv
module sniff_rd_xform #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   input  logic              rev_en,
   input  logic              inv_en,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] rev;

   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      assign rev[k] = din[DATA_W-1-k];
   end

   assign dout = (rev_en ? rev : din) ^ {DATA_W{inv_en}};

endmodule

// File: rtl/dma_cksum_sniffer.sv
module dma_cksum_sniffer
   import sniff_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          NUM_CHAN   = 16,
   parameter logic [31:0] CRC32_POLY = 32'h04C1_1DB7,
   parameter logic [15:0] CRC16_POLY = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              obs_valid,
   input  logic [SEL_W-1:0]  obs_chan,
   input  logic [DATA_W-1:0] obs_data
);

   localparam logic [1:0] OFF_CTRL = 2'd0;
   localparam logic [1:0] OFF_RES  = 2'd1;

   if (DATA_W != 32) begin : g_bad_width
      $error("dma_cksum_sniffer: DATA_W must be 32");
   end
   if (NUM_CHAN < 1 || NUM_CHAN > (1 << SEL_W)) begin : g_bad_chan
      $error("dma_cksum_sniffer: NUM_CHAN out of range");
   end

   sniff_ctrl_t       ctrl_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] fold_in;
   logic [DATA_W-1:0] rd_res;
   logic              hit;
   logic              in_rev;
   logic              ld_res;

   sniff_ctrl_reg u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr && reg_addr == OFF_CTRL),
      .wdata  (reg_wdata[CTRL_W-1:0]),
      .ctrl_q (ctrl_q)
   );

   assign in_rev = (ctrl_q.mode == M_CRC32_BR) || (ctrl_q.mode == M_CRC16_BR);

   sniff_in_xform #(.DATA_W(DATA_W)) u_in (
      .din     (obs_data),
      .swap_en (ctrl_q.in_swap),
      .rev_en  (in_rev),
      .dout    (fold_in)
   );

   assign hit    = ctrl_q.en && obs_valid && (obs_chan == ctrl_q.chan);
   assign ld_res = reg_wr && (reg_addr == OFF_RES);

   sniff_accum #(
      .DATA_W     (DATA_W),
      .CRC32_POLY (CRC32_POLY),
      .CRC16_POLY (CRC16_POLY)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (hit),
      .mode   (ctrl_q.mode),
      .din    (fold_in),
      .ld     (ld_res),
      .ld_val (reg_wdata),
      .acc_q  (acc_q)
   );

   sniff_rd_xform #(.DATA_W(DATA_W)) u_rd (
      .din    (acc_q),
      .rev_en (ctrl_q.rd_rev),
      .inv_en (ctrl_q.rd_inv),
      .dout   (rd_res)
   );

   always_comb begin
      case (reg_addr)
         OFF_CTRL: reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
         OFF_RES:  reg_rdata = rd_res;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sniff_checker.sv
module sniff_checker
   import sniff_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             obs_valid,
   input logic [SEL_W-1:0] obs_chan,
   input sniff_ctrl_t      ctrl,
   input logic [31:0]      acc
);

   logic load, take, known_mode;
   assign load       = reg_wr && reg_addr == 2'd1;
   assign take       = ctrl.en && obs_valid && obs_chan == ctrl.chan && !load;
   assign known_mode = ctrl.mode inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd14, 4'd15};

   a_r9_other_chan: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_valid && obs_chan != ctrl.chan && !load) |=> $stable(acc));

   a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.en && !load) |=> $stable(acc));

   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> acc == $past(reg_wdata));

   a_r4_crc16_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (ctrl.mode == 4'd2 || ctrl.mode == 4'd3)) |=> acc[31:16] == 16'h0);

   a_r6_parity_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ctrl.mode == 4'd14) |=> acc[31:1] == 31'h0);

   a_r12_unused_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (!known_mode && !load) |=> $stable(acc));

   a_r10_inv_read: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.rd_inv && !ctrl.rd_rev && reg_addr == 2'd1) |-> reg_rdata == ~acc);

endmodule

bind dma_cksum_sniffer sniff_checker i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .obs_valid (obs_valid),
   .obs_chan  (obs_chan),
   .ctrl      (ctrl_q),
   .acc       (acc_q)
);

// File: tb/test_dma_cksum_sniffer.sv
module test_dma_cksum_sniffer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        obs_valid = 1'b0;
   logic [3:0]  obs_chan = '0;
   logic [31:0] obs_data = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [11:0] m_ctrl = '0;
   logic [31:0] m_res  = '0;
   logic [31:0] rnd    = 32'h1357_9BDF;

   always #4 clk = ~clk;

   dma_cksum_sniffer i_dma_cksum_sniffer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .obs_valid(obs_valid),
      .obs_chan(obs_chan), .obs_data(obs_data)
   );

   function automatic logic [31:0] bswap32(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   function automatic logic [31:0] brev32(input logic [31:0] x);
      logic [31:0] r = '0;
      for (int i = 0; i < 32; i++) r[31-i] = x[i];
      return r;
   endfunction

   function automatic logic [31:0] ref_crc(input logic [31:0] seed, input logic [31:0] d,
                                           input int width, input logic [31:0] poly);
      longint unsigned reg_v = seed;
      longint unsigned msk = (64'd1 << width) - 1;
      reg_v = reg_v & msk;
      for (int i = 31; i >= 0; i--) begin
         reg_v = reg_v << 1;
         if ((((reg_v >> width) & 1) ^ d[i]) != 0) reg_v = reg_v ^ poly;
         reg_v = reg_v & msk;
      end
      return reg_v[31:0];
   endfunction

   function automatic logic [11:0] mk(input bit en, input int ch, input int mode,
                                      input bit sw, input bit rv, input bit iv);
      return {iv, rv, sw, mode[3:0], ch[3:0], en};
   endfunction

   function automatic logic [31:0] expect_rd(input logic [1:0] a);
      logic [31:0] r;
      if (a == 2'd0) return {20'h0, m_ctrl};
      if (a != 2'd1) return '0;
      r = m_res;
      if (m_ctrl[10]) r = brev32(r);
      if (m_ctrl[11]) r = ~r;
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   // One clock: drive at falling edge, compare the read port, then
   // advance the model with the same stimulus the design sees.
   task automatic tick(input bit wr, input logic [1:0] a, input logic [31:0] wd,
                       input bit v, input int ch, input logic [31:0] d, input string req);
      logic [31:0] x;
      reg_wr = wr; reg_addr = a; reg_wdata = wd;
      obs_valid = v; obs_chan = ch[3:0]; obs_data = d;
      #1;
      check(req, reg_rdata, expect_rd(a));
      if (wr && a == 2'd1) m_res = wd;
      else if (v && m_ctrl[0] && ch[3:0] == m_ctrl[4:1]) begin
         x = m_ctrl[9] ? bswap32(d) : d;
         if (m_ctrl[8:5] == 4'd1 || m_ctrl[8:5] == 4'd3) x = brev32(x);
         case (m_ctrl[8:5])
            4'd0, 4'd1: m_res = ref_crc(m_res, x, 32, 32'h04C11DB7);
            4'd2, 4'd3: m_res = ref_crc(m_res, x, 16, 32'h1021);
            4'd14:      m_res = {31'h0, m_res[0] ^ ($countones(x) % 2 == 1)};
            4'd15:      m_res = m_res + x;
            default:    ;
         endcase
      end
      if (wr && a == 2'd0) m_ctrl = wd[11:0];
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_ctrl(input logic [11:0] c, input string req);
      tick(1, 2'd0, {20'h0, c}, 0, 0, '0, req);
   endtask

   task automatic seed(input logic [31:0] s, input string req);
      tick(1, 2'd1, s, 0, 0, '0, req);
   endtask

   task automatic feed(input int ch, input logic [31:0] d, input string req);
      tick(0, 2'd1, '0, 1, ch, d, req);
   endtask

   task automatic feed_rand(input int ch, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
         feed(ch, rnd, req);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tick(0, 2'd0, '0, 0, 0, '0, "R1");
      tick(0, 2'd1, '0, 0, 0, '0, "R1");
      tick(0, 2'd2, '0, 0, 0, '0, "R2");
      tick(0, 2'd3, '0, 0, 0, '0, "R2");
      set_ctrl(12'hFFF, "R2");
      tick(0, 2'd0, '0, 0, 0, '0, "R2");
      tick(0, 2'd2, '0, 0, 0, '0, "R2");

      // R3 CRC-32
      set_ctrl(mk(1, 3, 0, 0, 0, 0), "R3");
      seed(32'hFFFF_FFFF, "R11");
      feed(3, 32'h1234_5678, "R3");
      feed(3, 32'h0000_0000, "R3");
      feed(3, 32'hFFFF_FFFF, "R3");
      feed_rand(3, 8, "R3");
      // R9 channel filter and enable
      feed(5, 32'hDEAD_BEEF, "R9");
      feed(2, 32'hCAFE_F00D, "R9");
      tick(0, 2'd1, '0, 0, 0, '0, "R9");
      set_ctrl(mk(0, 3, 0, 0, 0, 0), "R9");
      feed(3, 32'hA5A5_5A5A, "R9");
      tick(0, 2'd1, '0, 0, 0, '0, "R9");
      // R5 bit-reversed CRC-32
      set_ctrl(mk(1, 7, 1, 0, 0, 0), "R5");
      feed_rand(7, 6, "R5");
      // R4 CRC-16
      set_ctrl(mk(1, 0, 2, 0, 0, 0), "R4");
      seed(32'h0000_FFFF, "R4");
      feed(0, 32'h3132_3334, "R4");
      feed_rand(0, 6, "R4");
      seed(32'hABCD_1234, "R4");
      feed(0, 32'h0000_0001, "R4");
      tick(0, 2'd1, '0, 0, 0, '0, "R4");
      // R5 bit-reversed CRC-16, then with byte swap (R8)
      set_ctrl(mk(1, 15, 3, 0, 0, 0), "R5");
      feed_rand(15, 5, "R5");
      set_ctrl(mk(1, 15, 3, 1, 0, 0), "R8");
      feed(15, 32'h0102_0304, "R8");
      feed_rand(15, 4, "R8");
      set_ctrl(mk(1, 1, 0, 1, 0, 0), "R8");
      feed_rand(1, 4, "R8");
      // R6 parity
      set_ctrl(mk(1, 4, 14, 0, 0, 0), "R6");
      seed(32'hFFFF_FFFE, "R6");
      feed(4, 32'h0000_0001, "R6");
      feed(4, 32'h0000_0003, "R6");
      feed(4, 32'h8000_0000, "R6");
      feed_rand(4, 6, "R6");
      tick(0, 2'd1, '0, 0, 0, '0, "R6");
      // R7 sum with wraparound
      set_ctrl(mk(1, 9, 15, 0, 0, 0), "R7");
      seed(32'hFFFF_FFF0, "R7");
      feed(9, 32'h0000_0020, "R7");
      feed(9, 32'hFFFF_FFFF, "R7");
      feed_rand(9, 5, "R7");
      set_ctrl(mk(1, 9, 15, 1, 0, 0), "R8");
      feed(9, 32'h0000_0001, "R8");
      tick(0, 2'd1, '0, 0, 0, '0, "R8");
      // R10 read-side transforms
      seed(32'h0000_00F1, "R10");
      set_ctrl(mk(1, 9, 15, 0, 1, 0), "R10");
      tick(0, 2'd1, '0, 0, 0, '0, "R10");
      feed(9, 32'h0000_0100, "R10");
      set_ctrl(mk(1, 9, 15, 0, 0, 1), "R10");
      feed(9, 32'h0000_0002, "R10");
      set_ctrl(mk(1, 9, 15, 0, 1, 1), "R10");
      feed(9, 32'h1000_0000, "R10");
      set_ctrl(mk(1, 9, 15, 0, 0, 0), "R10");
      tick(0, 2'd1, '0, 0, 0, '0, "R10");
      // R12 unused mode codes
      set_ctrl(mk(1, 9, 5, 0, 0, 0), "R12");
      feed(9, 32'h1111_1111, "R12");
      set_ctrl(mk(1, 9, 13, 0, 0, 0), "R12");
      feed(9, 32'h2222_2222, "R12");
      tick(0, 2'd1, '0, 0, 0, '0, "R12");
      // R11 write beats a same-cycle transfer
      set_ctrl(mk(1, 6, 0, 0, 0, 0), "R11");
      tick(1, 2'd1, 32'h5555_AAAA, 1, 6, 32'h0F0F_0F0F, "R11");
      tick(0, 2'd1, '0, 0, 0, '0, "R11");
      // R13 control write with a same-cycle transfer uses old settings
      tick(1, 2'd0, {20'h0, mk(1, 6, 15, 0, 0, 0)}, 1, 6, 32'h0000_0010, "R13");
      tick(0, 2'd1, '0, 0, 0, '0, "R13");
      feed(6, 32'h0000_0010, "R13");
      tick(0, 2'd1, '0, 0, 0, '0, "R13");
      tick(0, 2'd0, '0, 0, 0, '0, "R13");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule